// File: doc/BRIEF.md
# Inter-Processor Doorbell and Timer-Acknowledge Register

This block is one control register of a four-processor chipset. Software on any processor writes it to ring a doorbell interrupt on one or more processors, to acknowledge a doorbell that was delivered, or to acknowledge a pending timer interrupt. Each processor has its own doorbell line, which is its level-3 interrupt request, and its own timer line.

Each doorbell is a single pending bit, not a counter. A request sets the bit only if it is clear. An acknowledge clears it only if it is set. Both are decoded from one write, and the request is applied before the acknowledge. Timer pending bits are set by a per-processor tick input and cleared by software.

A read returns both groups of pending bits at fixed positions. A write that touches none of the recognised fields is flagged as unsupported in the same cycle.

Top module: `cpu_doorbell_reg`

## Requirements
- R1: An asynchronous active-low reset clears every doorbell and timer pending bit at once. While reset is held, `irq_ipi`, `irq_tmr` and `rd_data` are all zero.
- R2: On a write (`wr_en`=1), a 1 in `wr_data` bit 12+n sets doorbell pending for processor n, and `irq_ipi[n]` is high from the next clock edge.
- R3: Repeated requests to a doorbell that is already pending are not counted, so a single acknowledge clears it.
- R4: On a write, a 1 in `wr_data` bit 8+n clears doorbell pending for processor n from the next edge. Acknowledging a doorbell that is not pending changes nothing.
- R5: A write that sets both bit 12+n and bit 8+n leaves processor n with no pending doorbell, whether or not one was pending before.
- R6: A 1 on `tmr_tick[n]` sets timer pending for processor n, and `irq_tmr[n]` is high from the next edge. A write with bit 4+n set clears it. If a tick and a clear for the same processor arrive in the same cycle, the tick wins.
- R7: A write whose only nonzero recognised field is bit 28 is accepted: `wr_unsup` stays low and no pending state changes.
- R8: `wr_unsup` is high in exactly the cycles where `wr_en` is high and bits 15:4 and bit 28 of `wr_data` are all zero. It is a combinational pulse that lines up with the strobe.
- R9: `rd_data` holds doorbell pending for processor n in bit 8+n and timer pending in bit 4+n. Every other bit reads zero.
- R10: When `wr_en` is low, `wr_data` has no effect on pending state or on `wr_unsup`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 64 | Write data |
| tmr_tick | input | 4 | Per-processor timer tick, sets timer pending |
| rd_data | output | 64 | Register read value |
| irq_ipi | output | 4 | Per-processor doorbell interrupt (level 3) |
| irq_tmr | output | 4 | Per-processor timer interrupt |
| wr_unsup | output | 1 | Pulse: the write touched no supported field |

## Verification
The assertions assume three things about the inputs. Reset is released well before any write. `wr_en` is a clean single-cycle strobe. `tmr_tick` is a synchronous level sampled at each edge, so it never settles between edges. The bench drives every input on the falling clock edge and only while reset is inactive, except in the directed test that asserts reset on purpose. That keeps every clocked property seeing whole cycles of stable input. The timer-tick and write-clear collision is created deliberately in one vector, so the priority property is exercised rather than left vacuous.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // Field positions decoded by software; these are part of the behaviour.
  localparam int TMR_LSB = 4;   // timer acknowledge / timer pending
  localparam int ACK_LSB = 8;   // doorbell acknowledge / doorbell pending
  localparam int REQ_LSB = 12;  // doorbell request
  localparam int NXM_BIT = 28;  // accepted, no effect
endpackage

// File: rtl/cdr_wr_decode.sv
module cdr_wr_decode
  import cdr_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [NCPU-1:0] ipi_req,
  output logic [NCPU-1:0] ipi_ack,
  output logic [NCPU-1:0] tmr_ack,
  output logic            wr_unsup
);
  localparam logic [DW-1:0] ONES_N = {{(DW-NCPU){1'b0}}, {NCPU{1'b1}}};
  localparam logic [DW-1:0] KNOWN  = (ONES_N << REQ_LSB) | (ONES_N << ACK_LSB)
                                   | (ONES_N << TMR_LSB) | (DW'(1) << NXM_BIT);

  logic known_hit;

  always_comb begin
    known_hit = |(wr_data & KNOWN);
    ipi_req   = wr_en ? wr_data[REQ_LSB +: NCPU] : '0;
    ipi_ack   = wr_en ? wr_data[ACK_LSB +: NCPU] : '0;
    tmr_ack   = wr_en ? wr_data[TMR_LSB +: NCPU] : '0;
    wr_unsup  = wr_en & ~known_hit;
  end

  // R8 / R10: the flag only ever appears with a strobe
  p_unsup_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unsup |-> wr_en);
  // R10: with no strobe, no field reaches the pending logic
  p_idle_no_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (ipi_req == '0 && ipi_ack == '0 && tmr_ack == '0));
endmodule

// File: rtl/cdr_ipi_slice.sv
module cdr_ipi_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic pend
);
  logic pend_nxt;
  logic pend_en;

  always_comb begin
    pend_nxt = pend;
    if (req) pend_nxt = 1'b1;   // set phase first
    if (ack) pend_nxt = 1'b0;   // then clear phase
    pend_en  = req | ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_nxt;
  end

  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> pend);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !pend);
  p_both_leaves_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !pend);
  p_hold_when_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !ack) |=> $stable(pend));
endmodule

// File: rtl/cdr_tmr_slice.sv
module cdr_tmr_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ack,
  output logic pend
);
  logic pend_nxt;
  logic pend_en;

  always_comb begin
    pend_nxt = pend;
    if (ack)  pend_nxt = 1'b0;
    if (tick) pend_nxt = 1'b1;  // tick overrides a same-cycle clear
    pend_en  = tick | ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_nxt;
  end

  p_tick_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend);
  p_tmr_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick) |=> !pend);
  p_tmr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !tick) |=> $stable(pend));
endmodule

// File: rtl/cpu_doorbell_reg.sv
module cpu_doorbell_reg
  import cdr_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCPU-1:0] tmr_tick,
  output logic [DW-1:0]   rd_data,
  output logic [NCPU-1:0] irq_ipi,
  output logic [NCPU-1:0] irq_tmr,
  output logic            wr_unsup
);
  logic [NCPU-1:0] ipi_req;
  logic [NCPU-1:0] ipi_ack;
  logic [NCPU-1:0] tmr_ack;
  logic [NCPU-1:0] ipi_pend;
  logic [NCPU-1:0] tmr_pend;

  cdr_wr_decode #(.DW(DW), .NCPU(NCPU)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ipi_req  (ipi_req),
    .ipi_ack  (ipi_ack),
    .tmr_ack  (tmr_ack),
    .wr_unsup (wr_unsup)
  );

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    cdr_ipi_slice u_ipi (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ipi_req[n]),
      .ack   (ipi_ack[n]),
      .pend  (ipi_pend[n])
    );
    cdr_tmr_slice u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tmr_tick[n]),
      .ack   (tmr_ack[n]),
      .pend  (tmr_pend[n])
    );
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[ACK_LSB +: NCPU]    = ipi_pend;
    rd_data[TMR_LSB +: NCPU]    = tmr_pend;
    irq_ipi                     = ipi_pend;
    irq_tmr                     = tmr_pend;
  end

  // R10: no strobe and no tick means the readable state is frozen
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tmr_tick == '0) |=> $stable(rd_data));
  // R7: a write carrying only the accepted error bit leaves the state alone
  p_nxm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:4] == '0 && tmr_tick == '0) |=> $stable(rd_data));
endmodule

// File: tb/cpu_doorbell_reg_bench.sv
module cpu_doorbell_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [3:0]  tmr_tick;
  logic [63:0] rd_data;
  logic [3:0]  irq_ipi;
  logic [3:0]  irq_tmr;
  logic        wr_unsup;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  cpu_doorbell_reg u_cpu_doorbell_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tmr_tick(tmr_tick), .rd_data(rd_data), .irq_ipi(irq_ipi),
    .irq_tmr(irq_tmr), .wr_unsup(wr_unsup)
  );

  typedef struct packed {
    logic        wr;
    logic [63:0] data;
    logic [3:0]  tick;
    logic [3:0]  e_ipi;
    logic [3:0]  e_tmr;
    logic        e_unsup;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 64'h5000, 4'h0, 4'b0101, 4'b0000, 1'b0, 8'd2},  // R2 request cpu0,cpu2
    '{1'b1, 64'h1000, 4'h0, 4'b0101, 4'b0000, 1'b0, 8'd3},  // R3 repeat request
    '{1'b1, 64'h0100, 4'h0, 4'b0100, 4'b0000, 1'b0, 8'd3},  // R3 one ack clears
    '{1'b1, 64'h0100, 4'h0, 4'b0100, 4'b0000, 1'b0, 8'd4},  // R4 ack when clear
    '{1'b1, 64'h2200, 4'h0, 4'b0100, 4'b0000, 1'b0, 8'd5},  // R5 both, was clear
    '{1'b1, 64'h4400, 4'h0, 4'b0000, 4'b0000, 1'b0, 8'd5},  // R5 both, was set
    '{1'b0, 64'h0000, 4'hA, 4'b0000, 4'b1010, 1'b0, 8'd6},  // R6 tick sets
    '{1'b1, 64'h0020, 4'h0, 4'b0000, 4'b1000, 1'b0, 8'd6},  // R6 clear cpu1
    '{1'b1, 64'h0080, 4'h8, 4'b0000, 4'b1000, 1'b0, 8'd6},  // R6 tick wins
    '{1'b1, 64'h0080, 4'h0, 4'b0000, 4'b0000, 1'b0, 8'd6},  // R6 clear cpu3
    '{1'b1, 64'h1000_0000, 4'h0, 4'b0000, 4'b0000, 1'b0, 8'd7}, // R7 bit 28
    '{1'b1, 64'h0001, 4'h0, 4'b0000, 4'b0000, 1'b1, 8'd8},  // R8 unknown bit
    '{1'b1, 64'h0000, 4'h0, 4'b0000, 4'b0000, 1'b1, 8'd8},  // R8 zero write
    '{1'b0, 64'hF000, 4'h0, 4'b0000, 4'b0000, 1'b0, 8'd10}, // R10 no strobe
    '{1'b1, 64'hF000, 4'h0, 4'b1111, 4'b0000, 1'b0, 8'd2},  // R2 all cpus
    '{1'b0, 64'h0F00, 4'h0, 4'b1111, 4'b0000, 1'b0, 8'd10}, // R10 no strobe
    '{1'b1, 64'hFFFF_0000_0000_0F00, 4'h0, 4'b0000, 4'b0000, 1'b0, 8'd9} // R9/R4
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: expected read image built from the stated field positions
  function automatic logic [63:0] image(input logic [3:0] ipi, input logic [3:0] tmr);
    return (64'(ipi) << 8) | (64'(tmr) << 4);
  endfunction

  task automatic check_state(input logic [3:0] ipi, input logic [3:0] tmr, input string req);
    check(rd_data == image(ipi, tmr), {req, " rd_data R9"}, rd_data, image(ipi, tmr));
    check(irq_ipi == ipi, {req, " irq_ipi"}, 64'(irq_ipi), 64'(ipi));
    check(irq_tmr == tmr, {req, " irq_tmr"}, 64'(irq_tmr), 64'(tmr));
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tmr_tick = '0;
    repeat (3) @(negedge clk);
    check_state(4'h0, 4'h0, "R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check_state(4'h0, 4'h0, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      wr_en = VECS[i].wr; wr_data = VECS[i].data; tmr_tick = VECS[i].tick;
      #1;
      check(wr_unsup == VECS[i].e_unsup, {tag, " wr_unsup R8"},
            64'(wr_unsup), 64'(VECS[i].e_unsup));
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; tmr_tick = '0;
      check_state(VECS[i].e_ipi, VECS[i].e_tmr, tag);
    end

    // R1: asynchronous reset from a fully loaded state
    wr_en = 1'b1; wr_data = 64'hF000; tmr_tick = 4'hF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tmr_tick = '0;
    check_state(4'hF, 4'hF, "R2 R6 load before reset");
    #1 rst_n = 1'b0;
    #1;
    check_state(4'h0, 4'h0, "R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state(4'h0, 4'h0, "R1 stays clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule